// File: doc/BRIEF.md
# Boundary Event Gate

This block sits beside an instruction sequencer. At every instruction boundary, marked by the retire strobe, it decides which event the core must service next, if any. The event can be an internal exception, a non-maskable interrupt, a debug fault, a single-step trap or a maskable interrupt. It reports one event code for that boundary. The choice depends on several flag-register fields taken together. The interrupt-enable bit masks the external level interrupt. The trap bit asks for a step event after every completed instruction. The resume bit refuses debug faults.

Separately, whenever an I/O instruction is presented, the block compares the current privilege level with the two-bit I/O privilege field. In the same cycle it raises a one-cycle protection-fault pulse if the instruction is not allowed. The block also produces the next value of the resume bit for the flag register. Vector fetch, stack frames and task switching are handled elsewhere.

Top module: `boundary_event_gate`

## Requirements
- R1: After reset `event_code` is 0 and `resume_out` is 0, and `prot_fault` is 0 while `io_strobe` is low.
- R2: A level interrupt on `irq_level` at a boundary gives code 5 when `ie_flag` is 1. When `ie_flag` is 0 it is ignored and the code is 0.
- R3: An internal exception request (`exc_req`, code 1) and a non-maskable interrupt (code 2) are accepted whatever the value of `ie_flag`.
- R4: With `trap_flag` at 1, every boundary gives the step code 4, provided nothing of higher rank is pending.
- R5: A debug fault (`dbg_fault`, code 3) is accepted when `resume_flag` is 0. When `resume_flag` is 1 it is refused and the code is 0.
- R6: When several events are pending at once, exactly one code is given, in this rank: code 1, then 2, then 3, then 4, then 5.
- R7: The NMI input is edge-triggered. A rising edge on `nmi_pin` is held until a boundary accepts it, even if the pin falls first. A pin held high yields only one acceptance, and an accepted NMI is not reported again.
- R8: The maskable interrupt is level-sensitive. A request removed before the boundary is not reported.
- R9: `event_code` is valid in the cycle after a cycle with `retire` high, for one cycle. It is 0 after any cycle without `retire`.
- R10: `prot_fault` is high in the same cycle as `io_strobe` exactly when `cpl` is greater than `iopl`, compared as unsigned two-bit values. It is low when `cpl <= iopl` and whenever `io_strobe` is low.
- R11: `resume_out`, updated one cycle after the cycle it reflects, behaves as follows:
  - It becomes 1 after a protection fault or after an accepted internal exception.
  - Otherwise it becomes 0 after a boundary.
  - Otherwise it follows `resume_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ie_flag | input | 1 | Interrupt-enable field of the flag register |
| trap_flag | input | 1 | Single-step trap field |
| resume_flag | input | 1 | Current resume field |
| iopl | input | 2 | I/O privilege level field |
| cpl | input | 2 | Current privilege level |
| irq_level | input | 1 | Maskable interrupt, level-sensitive |
| nmi_pin | input | 1 | Non-maskable interrupt, rising-edge |
| exc_req | input | 1 | Internal exception request |
| dbg_fault | input | 1 | Pending debug fault |
| retire | input | 1 | Instruction completed (boundary strobe) |
| io_strobe | input | 1 | An I/O instruction is being issued |
| event_code | output | 3 | Selected event: 0 none, 1 exception, 2 NMI, 3 debug, 4 step, 5 interrupt |
| prot_fault | output | 1 | Protection-fault pulse for a denied I/O instruction |
| resume_out | output | 1 | Updated resume field |

## Verification
`event_code` and `resume_out` come from registers. Each is due one clock after the edge that samples `retire` or `io_strobe`. `prot_fault` is combinational and is due in the cycle of the strobe itself.

The bench drives every stimulus at a falling edge. It checks `prot_fault` one nanosecond later. At the same moment it pushes the expected registered results into a queue. A monitor pops that queue one nanosecond after the next rising edge, so each expected item is compared in exactly the cycle the registers show it. The NMI sequences span several cycles, so that held edges, edges on the boundary itself and held-high pins are each told apart.

// File: rtl/evt_pkg.sv
// Package: shared event codes and source ordering for the boundary event gate.
// Assumes: source index i in the request vector maps to event code i+1,
// so the index order is also the service rank (index 0 wins).
package evt_pkg;

    localparam int unsigned CODE_W = 3;
    localparam int unsigned N_SRC  = 5;

    typedef enum logic [CODE_W-1:0] {
        EV_NONE = 3'd0,
        EV_EXC  = 3'd1,
        EV_NMI  = 3'd2,
        EV_DBG  = 3'd3,
        EV_STEP = 3'd4,
        EV_IRQ  = 3'd5
    } ev_code_e;

    // Positions in the request vector (rank order).
    localparam int unsigned SRC_EXC  = 0;
    localparam int unsigned SRC_NMI  = 1;
    localparam int unsigned SRC_DBG  = 2;
    localparam int unsigned SRC_STEP = 3;
    localparam int unsigned SRC_IRQ  = 4;

endpackage

// File: rtl/nmi_capture.sv
// Module: nmi_capture
// Turns the non-maskable interrupt pin into a pending request. A rising edge
// sets the request, which stays set until the arbiter accepts it. The edge is
// visible as pending in the very cycle it occurs.
// Assumes: nmi_pin is already synchronous to clk.
module nmi_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_pin,
    input  logic accept,
    output logic pending
);

    logic pin_q;
    logic held_q;
    logic edge_now;

    // Detect a low-to-high transition against the previous sample.
    assign edge_now = nmi_pin & ~pin_q;
    assign pending  = held_q | edge_now;

    // Keep the previous pin sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= nmi_pin;
    end

    // Hold a captured edge until the arbiter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= 1'b0;
        else if (accept) held_q <= 1'b0;
        else             held_q <= pending;
    end

endmodule

// File: rtl/prio_select.sv
// Module: prio_select
// Fixed-rank selector: the lowest-index active request wins. It returns a
// one-hot grant and the matching event code (index + 1, 0 when idle).
// Assumes: N fits in the code width minus the idle value.
module prio_select #(
    parameter int unsigned N      = 5,
    parameter int unsigned CODE_W = 3
) (
    input  logic [N-1:0]      req,
    output logic [N-1:0]      gnt,
    output logic [CODE_W-1:0] code
);

    logic [N-1:0] blocked;

    assign blocked[0] = 1'b0;

    // Build the "something of higher rank is active" chain, one stage per source.
    for (genvar i = 1; i < N; i++) begin : g_chain
        assign blocked[i] = blocked[i-1] | req[i-1];
    end

    assign gnt = req & ~blocked;

    // Encode the single grant into its event code.
    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) code = CODE_W'(i + 1);
        end
    end

endmodule

// File: rtl/io_permit.sv
// Module: io_permit
// Privilege compare for I/O instructions. A denied instruction raises a fault
// in the same cycle as its strobe.
// Assumes: a lower number means more privilege; both levels are unsigned.
module io_permit #(
    parameter int unsigned PL_W = 2
) (
    input  logic            io_strobe,
    input  logic [PL_W-1:0] cpl,
    input  logic [PL_W-1:0] iopl,
    output logic            fault
);

    logic allowed;

    // Allowed when the current level is no less privileged than the field.
    assign allowed = (cpl <= iopl);
    assign fault   = io_strobe & ~allowed;

endmodule

// File: rtl/resume_track.sv
// Module: resume_track
// Produces the next resume flag value:
//   - set on a non-debug fault (accepted exception or I/O protection fault);
//   - otherwise cleared at an instruction boundary;
//   - otherwise copied from the current flag.
// Assumes: all inputs are sampled on the same edge.
module resume_track (
    input  logic clk,
    input  logic rst_n,
    input  logic resume_in,
    input  logic boundary,
    input  logic exc_taken,
    input  logic io_fault,
    output logic resume_out
);

    // Register the updated flag according to the three rules above.
    always_ff @(posedge clk) begin
        if (!rst_n)                      resume_out <= 1'b0;
        else if (exc_taken || io_fault)  resume_out <= 1'b1;
        else if (boundary)               resume_out <= 1'b0;
        else                             resume_out <= resume_in;
    end

endmodule

// File: rtl/boundary_event_gate.sv
// Module: boundary_event_gate (top)
// At each retire strobe, gathers the pending events and qualifies each one with
// its flag field. It ranks them and registers one event code for the next
// cycle. It also gates I/O instructions by privilege and tracks the resume flag.
// Assumes: all inputs are synchronous to clk; reset is synchronous and
// active-low.
module boundary_event_gate #(
    parameter int unsigned PL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ie_flag,
    input  logic             trap_flag,
    input  logic             resume_flag,
    input  logic [PL_W-1:0]  iopl,
    input  logic [PL_W-1:0]  cpl,
    input  logic             irq_level,
    input  logic             nmi_pin,
    input  logic             exc_req,
    input  logic             dbg_fault,
    input  logic             retire,
    input  logic             io_strobe,
    output logic [2:0]       event_code,
    output logic             prot_fault,
    output logic             resume_out
);

    import evt_pkg::*;

    logic [N_SRC-1:0]  req;
    logic [N_SRC-1:0]  gnt;
    logic [CODE_W-1:0] sel_code;
    logic              nmi_pending;
    logic              nmi_accept;
    logic              exc_taken;

    // Qualify each source with the flag field that governs it.
    always_comb begin
        req           = '0;
        req[SRC_EXC]  = exc_req;
        req[SRC_NMI]  = nmi_pending;
        req[SRC_DBG]  = dbg_fault & ~resume_flag;
        req[SRC_STEP] = trap_flag;
        req[SRC_IRQ]  = irq_level & ie_flag;
    end

    assign nmi_accept = retire & gnt[SRC_NMI];
    assign exc_taken  = retire & gnt[SRC_EXC];

    nmi_capture u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_pin (nmi_pin),
        .accept  (nmi_accept),
        .pending (nmi_pending)
    );

    prio_select #(
        .N      (N_SRC),
        .CODE_W (CODE_W)
    ) u_sel (
        .req  (req),
        .gnt  (gnt),
        .code (sel_code)
    );

    io_permit #(
        .PL_W (PL_W)
    ) u_io (
        .io_strobe (io_strobe),
        .cpl       (cpl),
        .iopl      (iopl),
        .fault     (prot_fault)
    );

    resume_track u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .resume_in  (resume_flag),
        .boundary   (retire),
        .exc_taken  (exc_taken),
        .io_fault   (prot_fault),
        .resume_out (resume_out)
    );

    // Register the chosen code for one cycle after a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      event_code <= EV_NONE;
        else if (retire) event_code <= sel_code;
        else             event_code <= EV_NONE;
    end

endmodule

// Module: boundary_event_gate_chk
// Property checker bound to the top; it observes the top's ports only.
module boundary_event_gate_chk #(
    parameter int unsigned PL_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ie_flag,
    input logic            resume_flag,
    input logic [PL_W-1:0] iopl,
    input logic [PL_W-1:0] cpl,
    input logic            exc_req,
    input logic            retire,
    input logic            io_strobe,
    input logic [2:0]      event_code,
    input logic            prot_fault,
    input logic            resume_out
);

    // R9: no boundary, no event.
    p_quiet_no_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> event_code == 3'd0);

    // R2: masked interrupt never reported.
    p_irq_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        retire && !ie_flag |=> event_code != 3'd5);

    // R6 / R3: an exception always wins its boundary.
    p_exc_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retire && exc_req |=> event_code == 3'd1);

    // R5: debug fault refused while resume is set.
    p_dbg_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        retire && resume_flag |=> event_code != 3'd3);

    // R10: no fault without an I/O strobe, none when permitted.
    p_fault_needs_io_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_strobe || cpl <= iopl) |-> !prot_fault);

    // R11: a clean boundary clears the resume flag.
    p_resume_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        retire && !exc_req && !prot_fault |=> !resume_out);

    // R11: a protection fault sets the resume flag.
    p_resume_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |=> resume_out);

endmodule

bind boundary_event_gate boundary_event_gate_chk #(.PL_W(PL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ie_flag     (ie_flag),
    .resume_flag (resume_flag),
    .iopl        (iopl),
    .cpl         (cpl),
    .exc_req     (exc_req),
    .retire      (retire),
    .io_strobe   (io_strobe),
    .event_code  (event_code),
    .prot_fault  (prot_fault),
    .resume_out  (resume_out)
);

// File: tb/test_boundary_event_gate.sv
`timescale 1ns/1ps
module test_boundary_event_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ie_flag = 0, trap_flag = 0, resume_flag = 0;
    logic [1:0] iopl = 0, cpl = 0;
    logic       irq_level = 0, nmi_pin = 0, exc_req = 0, dbg_fault = 0;
    logic       retire = 0, io_strobe = 0;
    logic [2:0] event_code;
    logic       prot_fault;
    logic       resume_out;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [2:0] code;
        logic       res;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    boundary_event_gate i_boundary_event_gate (
        .clk(clk), .rst_n(rst_n), .ie_flag(ie_flag), .trap_flag(trap_flag),
        .resume_flag(resume_flag), .iopl(iopl), .cpl(cpl), .irq_level(irq_level),
        .nmi_pin(nmi_pin), .exc_req(exc_req), .dbg_fault(dbg_fault),
        .retire(retire), .io_strobe(io_strobe), .event_code(event_code),
        .prot_fault(prot_fault), .resume_out(resume_out)
    );

    // Record one comparison.
    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Set all inputs for the next cycle (called just after a falling edge).
    task automatic drive(input logic ie, tf, rf, irq, nmi, exc, dbg, ret, io,
                         input logic [1:0] c, l);
        ie_flag = ie; trap_flag = tf; resume_flag = rf; irq_level = irq;
        nmi_pin = nmi; exc_req = exc; dbg_fault = dbg; retire = ret;
        io_strobe = io; cpl = c; iopl = l;
    endtask

    // Driver: check the same-cycle fault, queue the registered results, advance.
    task automatic cyc(input logic [2:0] code, input logic res, input logic pf,
                       input string tag);
        exp_t e;
        #1;
        check({tag, " prot_fault"}, int'(prot_fault), int'(pf));
        e.code = code; e.res = res; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare queued expectations just after the edge that produces them.
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            #1;
            e = sb_q.pop_front();
            check({e.tag, " event_code"}, int'(event_code), int'(e.code));
            check({e.tag, " resume_out"}, int'(resume_out), int'(e.res));
        end
    end

    // Watchdog.
    initial begin
        #100000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset event_code", int'(event_code), 0);
        check("R1 reset resume_out", int'(resume_out), 0);
        check("R1 reset prot_fault", int'(prot_fault), 0);
        rst_n = 1'b1;
        @(negedge clk);
        //     ie tf rf irq nmi exc dbg ret io cpl iopl
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, "R9 idle");
        drive(1, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0); cyc(5, 0, 0, "R2 irq enabled");
        drive(0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, "R2 irq masked");
        drive(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, "R9 irq no boundary");
        drive(0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0); cyc(1, 1, 0, "R3 R11 exception ie=0");
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, "R11 clean boundary");
        drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, "R7 nmi edge held");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, "R7 nmi pin dropped");
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); cyc(2, 0, 0, "R7 R3 held nmi taken");
        drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, "R7 nmi cleared");
        drive(0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0); cyc(2, 0, 0, "R7 nmi edge at boundary");
        drive(0, 0, 0, 0, 1, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, "R7 nmi level no repeat");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, "R9 nmi low");
        drive(0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0); cyc(4, 0, 0, "R4 step 1");
        drive(0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0); cyc(4, 0, 0, "R4 step 2");
        drive(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0); cyc(3, 0, 0, "R5 debug accepted");
        drive(0, 0, 1, 0, 0, 0, 1, 1, 0, 0, 0); cyc(0, 0, 0, "R5 debug refused");
        drive(1, 1, 0, 1, 1, 1, 1, 1, 0, 0, 0); cyc(1, 1, 0, "R6 all pending");
        drive(1, 1, 0, 1, 1, 0, 1, 1, 0, 0, 0); cyc(2, 0, 0, "R6 nmi next");
        drive(1, 1, 0, 1, 1, 0, 1, 1, 0, 0, 0); cyc(3, 0, 0, "R6 debug next");
        drive(1, 1, 0, 1, 1, 0, 0, 1, 0, 0, 0); cyc(4, 0, 0, "R6 step next");
        drive(1, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0); cyc(5, 0, 0, "R6 irq last");
        drive(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, "R8 irq withdrawn");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 3, 2); cyc(0, 1, 1, "R10 R11 io denied");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 2); cyc(0, 0, 0, "R10 io equal level");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 3); cyc(0, 0, 0, "R10 io privileged");
        drive(0, 0, 1, 0, 0, 0, 0, 0, 0, 3, 0); cyc(0, 1, 0, "R10 R11 no strobe, follow");
        drive(0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0); cyc(0, 0, 0, "R11 boundary clears");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule